// File: doc/BRIEF.md
# Multidrop Serial Transceiver with Address Wakeup

This block is an asynchronous serial transmitter and receiver for a bus on which one master talks to several slaves over a shared line. Each frame starts with a low start bit. The data bits follow, least-significant bit first. An optional extra bit comes next, and the frame ends with one high stop bit. In eight-bit mode the extra bit is an even parity bit, present only when parity is enabled. In nine-bit mode the extra bit is always present: it is written from `tx_bit8` and captured into `rx_bit8`. A set ninth bit marks an address frame. With wakeup enabled in nine-bit mode, a slave drops every frame whose ninth bit is clear. Data meant for other nodes therefore raises no interrupt and leaves the buffer untouched.

The register-style side gives the following controls. A transmit data load sets off a frame. A receive buffer is backed by a full flag that `rx_read` clears. Three error flags sit in `status[4:2]`, and software tests them by masking with 8'b00011100; `stat_read` clears them. `rx_irq` is a one-cycle interrupt pulse. Bit timing comes from a tick divider: one tick every `CLK_DIV` clocks and `OVS` ticks per bit. The transmit pin can be driven push-pull, or as open-drain so that several slaves can share the return line.

The transmitter walks the states TX_IDLE, TX_START, TX_DATA, TX_EXTRA and TX_STOP:
- TX_IDLE goes to TX_START on a load.
- Each later state ends after `OVS` ticks.
- TX_DATA goes to TX_EXTRA after the last data bit when an extra bit is present, and to TX_STOP otherwise.
- TX_EXTRA goes to TX_STOP.
- TX_STOP goes back to TX_IDLE.

The receiver walks the states RX_IDLE, RX_START, RX_DATA, RX_EXTRA and RX_STOP:
- RX_IDLE arms once it sees the line high. It goes to RX_START when an armed tick sees the line low.
- RX_START goes to RX_DATA if the line is still low `OVS/2` ticks later, and back to RX_IDLE if it is not.
- RX_DATA goes to RX_EXTRA or RX_STOP after the last data bit.
- RX_EXTRA goes to RX_STOP.
- RX_STOP samples the stop bit, reports the frame and returns to RX_IDLE.

Top module: `mpwake_uart`

## Requirements
- R1: `mode_sel` equal to 2'b11 selects nine-bit mode. Every other value selects eight-bit mode. Each bit lasts `OVS` ticks of `CLK_DIV` clocks. A frame is a low start bit, then eight data bits LSB first, then the extra bit when present, then one high stop bit.
- R2: A `tx_load` pulse while `tx_busy` is low starts a frame, and `tx_busy` stays high until the stop bit ends. A `tx_load` while busy is ignored. When idle, the line is released high.
- R3: The transmit extra bit is `tx_bit8` in nine-bit mode. In eight-bit mode with `par_en`=1 it is the even parity bit, the XOR of the data bits. In eight-bit mode with `par_en`=0 there is no extra bit.
- R4: With `od_en`=1, `txd_o` is 0 and `txd_oe` is 1 only while a low bit is sent. With `od_en`=0, `txd_oe` is 1 and `txd_o` carries the bit.
- R5: A received frame loads `rx_data`, sets `status[0]` (buffer full) and gives a one-cycle `rx_irq` pulse. A low on the line that has ended by the start-bit midpoint is ignored.
- R6: In nine-bit mode the received ninth bit is stored in `rx_bit8` and `status[7]`, and `par_en` has no effect.
- R7: In eight-bit mode with `par_en`=1, a received frame whose data and parity bit hold an odd count of ones sets `status[3]`.
- R8: A low stop bit sets `status[2]`. The frame is still loaded.
- R9: A frame that completes while `status[0]` is set sets `status[4]`. `rx_data` and `rx_bit8` keep the old frame, and no `rx_irq` is given.
- R10: In nine-bit mode with `wake_en`=1, a frame whose ninth bit is 0 is dropped. It gives no `rx_irq` and changes neither the buffer nor any flag. Frames whose ninth bit is 1 are received normally.
- R11: A `stat_read` pulse clears `status[4:2]`. An `rx_read` pulse clears `status[0]`.
- R12: After reset, `status`, `rx_data`, `rx_bit8`, `rx_irq` and `tx_busy` are 0, and the transmit line is idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | 2'b11 nine-bit mode, other values eight-bit mode |
| par_en | input | 1 | Even parity enable (eight-bit mode only) |
| wake_en | input | 1 | Address wakeup enable (nine-bit mode only) |
| od_en | input | 1 | Open-drain transmit pin |
| tx_data | input | 8 | Transmit data |
| tx_bit8 | input | 1 | Transmit ninth bit |
| tx_load | input | 1 | Start transmitting `tx_data` |
| tx_busy | output | 1 | Transmitter active |
| rx_data | output | 8 | Receive buffer |
| rx_bit8 | output | 1 | Received ninth bit |
| rx_read | input | 1 | Buffer read pulse, clears full |
| stat_read | input | 1 | Status read pulse, clears error flags |
| status | output | 8 | [7] ninth bit, [4] overrun, [3] parity, [2] framing, [0] full, others 0 |
| rx_irq | output | 1 | Receive interrupt pulse |
| rxd | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit value |
| txd_oe | output | 1 | Serial transmit drive enable |

## Verification
The hardest situations to reach are those where a completed frame must have no visible effect. One is a data frame dropped under wakeup. Another is an overrun, where the old buffer has to survive a second frame. A third is a start glitch that is rejected at its midpoint. In each case the only evidence is that nothing changed. The bench first loads a known frame into the buffer and counts interrupt pulses. It then sends the frame that must be dropped or rejected, and afterwards checks that the buffer value, the status byte and the interrupt count are all unchanged. A frame with a low stop bit is followed by a return to high, so that the receiver must re-arm before it accepts the next start bit.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam logic [1:0] MODE_NINE = 2'b11;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_EXTRA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_EXTRA,
        RX_STOP
    } rx_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       bit8;
        logic       par_err;
        logic       frame_err;
    } rx_frame_t;

endpackage

// File: rtl/mpu_tick_gen.sv
module mpu_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    generate
        if (DIV > 1) begin : g_div
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                    tick  <= 1'b0;
                end else begin
                    tick <= (cnt_q == CW'(DIV - 1));
                    if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
                    else                       cnt_q <= cnt_q + 1'b1;
                end
            end
        end else begin : g_nodiv
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                    tick  <= 1'b0;
                end else begin
                    cnt_q <= '0;
                    tick  <= 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/mpu_tx.sv
module mpu_tx
    import mpu_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          nine,
    input  logic          par_en,
    input  logic          load,
    input  logic [DW-1:0] data,
    input  logic          bit8,
    output logic          line,
    output logic          busy
);
    localparam int OCW = $clog2(OVS);
    localparam int IW  = $clog2(DW);

    tx_state_t     st_q, st_d;
    logic [OCW-1:0] ocnt_q;
    logic [IW-1:0]  idx_q;
    logic [DW-1:0]  sh_q;
    logic           ext_q;
    logic           has_ext_q;
    logic           bit_end;

    assign bit_end = tick && (ocnt_q == OCW'(OVS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (load) st_d = TX_START;
            TX_START: if (bit_end) st_d = TX_DATA;
            TX_DATA:  if (bit_end && idx_q == IW'(DW - 1))
                          st_d = has_ext_q ? TX_EXTRA : TX_STOP;
            TX_EXTRA: if (bit_end) st_d = TX_STOP;
            TX_STOP:  if (bit_end) st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    // frame datapath: bit timer, bit index, shift data, extra bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocnt_q    <= '0;
            idx_q     <= '0;
            sh_q      <= '0;
            ext_q     <= 1'b0;
            has_ext_q <= 1'b0;
        end else if (st_q == TX_IDLE) begin
            ocnt_q <= '0;
            idx_q  <= '0;
            if (load) begin
                sh_q      <= data;
                ext_q     <= nine ? bit8 : ^data;
                has_ext_q <= nine | par_en;
            end
        end else if (tick) begin
            ocnt_q <= bit_end ? '0 : ocnt_q + 1'b1;
            if (bit_end && st_q == TX_DATA) idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        line = 1'b1;
        busy = 1'b1;
        unique case (st_q)
            TX_IDLE:  busy = 1'b0;
            TX_START: line = 1'b0;
            TX_DATA:  line = sh_q[idx_q];
            TX_EXTRA: line = ext_q;
            TX_STOP:  line = 1'b1;
            default:  line = 1'b1;
        endcase
    end
endmodule

// File: rtl/mpu_rx.sv
module mpu_rx
    import mpu_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd,
    input  logic      nine,
    input  logic      par_en,
    output logic      done,
    output rx_frame_t frame
);
    localparam int OCW = $clog2(OVS);
    localparam int IW  = $clog2(DW);

    rx_state_t      st_q, st_d;
    logic [1:0]     sync_q;
    logic           rxs;
    logic           armed_q;
    logic [OCW-1:0] ocnt_q;
    logic [IW-1:0]  idx_q;
    logic [DW-1:0]  sh_q;
    logic           ext_q;
    logic           has_ext;
    logic           bit_end;
    logic           mid_start;

    assign rxs       = sync_q[1];
    assign has_ext   = nine | par_en;
    assign bit_end   = tick && (ocnt_q == OCW'(OVS - 1));
    assign mid_start = tick && (ocnt_q == OCW'(OVS / 2 - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:  if (tick && armed_q && !rxs) st_d = RX_START;
            RX_START: if (mid_start) st_d = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && idx_q == IW'(DW - 1))
                          st_d = has_ext ? RX_EXTRA : RX_STOP;
            RX_EXTRA: if (bit_end) st_d = RX_STOP;
            RX_STOP:  if (bit_end) st_d = RX_IDLE;
            default:  st_d = RX_IDLE;
        endcase
    end

    // sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            ocnt_q  <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            ext_q   <= 1'b0;
        end else begin
            unique case (st_q)
                RX_IDLE: begin
                    ocnt_q <= '0;
                    idx_q  <= '0;
                    ext_q  <= 1'b0;
                    if (tick) armed_q <= armed_q ? rxs | armed_q : rxs;
                    if (st_d == RX_START) armed_q <= 1'b0;
                end
                RX_START: begin
                    if (mid_start)  ocnt_q <= '0;
                    else if (tick)  ocnt_q <= ocnt_q + 1'b1;
                end
                RX_DATA: begin
                    if (tick) ocnt_q <= bit_end ? '0 : ocnt_q + 1'b1;
                    if (bit_end) begin
                        sh_q[idx_q] <= rxs;
                        idx_q       <= idx_q + 1'b1;
                    end
                end
                RX_EXTRA: begin
                    if (tick) ocnt_q <= bit_end ? '0 : ocnt_q + 1'b1;
                    if (bit_end) ext_q <= rxs;
                end
                RX_STOP: begin
                    if (tick) ocnt_q <= bit_end ? '0 : ocnt_q + 1'b1;
                end
                default: ocnt_q <= '0;
            endcase
        end
    end

    // outputs: frame report registered at the stop-bit sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= (st_q == RX_STOP) && bit_end;
            if ((st_q == RX_STOP) && bit_end) begin
                frame.data      <= sh_q;
                frame.bit8      <= nine & ext_q;
                frame.par_err   <= !nine && par_en && ((^sh_q) ^ ext_q);
                frame.frame_err <= !rxs;
            end
        end
    end
endmodule

// File: rtl/mpwake_uart.sv
module mpwake_uart
    import mpu_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int OVS     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       par_en,
    input  logic       wake_en,
    input  logic       od_en,
    input  logic [7:0] tx_data,
    input  logic       tx_bit8,
    input  logic       tx_load,
    output logic       tx_busy,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    input  logic       rx_read,
    input  logic       stat_read,
    output logic [7:0] status,
    output logic       rx_irq,
    input  logic       rxd,
    output logic       txd_o,
    output logic       txd_oe
);
    localparam int DW = 8;

    logic      tick;
    logic      nine;
    logic      tx_line;
    logic      rx_done;
    rx_frame_t rx_frm;
    logic      rx_new_b8;
    logic      drop;
    logic      full_q, ovr_q, perr_q, ferr_q;

    assign nine      = (mode_sel == MODE_NINE);
    assign rx_new_b8 = rx_frm.bit8;
    assign drop      = nine && wake_en && !rx_frm.bit8;

    mpu_tick_gen #(.DIV(CLK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    mpu_tx #(.OVS(OVS), .DW(DW)) tx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .nine   (nine),
        .par_en (par_en),
        .load   (tx_load),
        .data   (tx_data),
        .bit8   (tx_bit8),
        .line   (tx_line),
        .busy   (tx_busy)
    );

    mpu_rx #(.OVS(OVS), .DW(DW)) rx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .rxd    (rxd),
        .nine   (nine),
        .par_en (par_en),
        .done   (rx_done),
        .frame  (rx_frm)
    );

    // receive buffer, flags and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_bit8 <= 1'b0;
            full_q  <= 1'b0;
            ovr_q   <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            rx_irq  <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (rx_read) full_q <= 1'b0;
            if (stat_read) begin
                ovr_q  <= 1'b0;
                perr_q <= 1'b0;
                ferr_q <= 1'b0;
            end
            if (rx_done && !drop) begin
                if (full_q) begin
                    ovr_q <= 1'b1;
                end else begin
                    rx_data <= rx_frm.data;
                    rx_bit8 <= rx_frm.bit8;
                    full_q  <= 1'b1;
                    rx_irq  <= 1'b1;
                    if (rx_frm.par_err)   perr_q <= 1'b1;
                    if (rx_frm.frame_err) ferr_q <= 1'b1;
                end
            end
        end
    end

    assign status = {rx_bit8, 2'b00, ovr_q, perr_q, ferr_q, 1'b0, full_q};

    // pin driver
    assign txd_o  = od_en ? 1'b0 : tx_line;
    assign txd_oe = od_en ? !tx_line : 1'b1;
endmodule

// File: rtl/mpu_checker.sv
module mpu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_irq,
    input logic       od_en,
    input logic       txd_o,
    input logic       txd_oe,
    input logic       tx_busy,
    input logic       stat_read,
    input logic       rx_read,
    input logic [7:0] status,
    input logic [7:0] rx_data,
    input logic       rx_done,
    input logic       nine,
    input logic       wake_en,
    input logic       rx_new_b8
);
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);  // R5

    AST_IRQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> status[0]);  // R5

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (txd_oe ? txd_o : 1'b1));  // R2

    AST_PP_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !od_en |-> txd_oe);  // R4

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_read && !rx_done) |=> (status[4:2] == 3'b000));  // R11

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !rx_read) |=> $stable(rx_data));  // R9

    AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && nine && wake_en && !rx_new_b8) |=> !rx_irq);  // R10
endmodule

bind mpwake_uart mpu_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_irq    (rx_irq),
    .od_en     (od_en),
    .txd_o     (txd_o),
    .txd_oe    (txd_oe),
    .tx_busy   (tx_busy),
    .stat_read (stat_read),
    .rx_read   (rx_read),
    .status    (status),
    .rx_data   (rx_data),
    .rx_done   (rx_done),
    .nine      (nine),
    .wake_en   (wake_en),
    .rx_new_b8 (rx_new_b8)
);

// File: tb/mpwake_uart_tb.sv
module mpwake_uart_tb_top;
    localparam int DIV = 2;
    localparam int OVS = 16;
    localparam int BIT = DIV * OVS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic       par_en = 1'b0, wake_en = 1'b0, od_en = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_bit8 = 1'b0, tx_load = 1'b0;
    logic       tx_busy;
    logic [7:0] rx_data;
    logic       rx_bit8;
    logic       rx_read = 1'b0, stat_read = 1'b0;
    logic [7:0] status;
    logic       rx_irq;
    logic       rxd = 1'b1;
    logic       txd_o, txd_oe;
    logic       line;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    assign line = txd_oe ? txd_o : 1'b1;

    mpwake_uart #(.CLK_DIV(DIV), .OVS(OVS)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .par_en(par_en),
        .wake_en(wake_en), .od_en(od_en), .tx_data(tx_data),
        .tx_bit8(tx_bit8), .tx_load(tx_load), .tx_busy(tx_busy),
        .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_read(rx_read),
        .stat_read(stat_read), .status(status), .rx_irq(rx_irq),
        .rxd(rxd), .txd_o(txd_o), .txd_oe(txd_oe)
    );

    always @(negedge clk) if (rx_irq) irq_cnt++;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic send_rx(input logic [7:0] d, input bit has_ext,
                           input logic ext, input logic stop_v);
        @(negedge clk) rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (has_ext) begin
            rxd = ext;
            repeat (BIT) @(negedge clk);
        end
        rxd = stop_v;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic pulse_read();
        @(negedge clk) rx_read = 1'b1;
        @(negedge clk) rx_read = 1'b0;
    endtask

    task automatic pulse_stat();
        @(negedge clk) stat_read = 1'b1;
        @(negedge clk) stat_read = 1'b0;
    endtask

    task automatic load_tx(input logic [7:0] d, input logic b8);
        @(negedge clk);
        tx_data = d; tx_bit8 = b8; tx_load = 1'b1;
        @(negedge clk) tx_load = 1'b0;
    endtask

    task automatic tx_capture(input int nb, output logic [11:0] got);
        int guard = 0;
        got = '0;
        while (line !== 1'b0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (BIT / 2) @(negedge clk);
        got[0] = line;
        for (int i = 1; i < nb; i++) begin
            repeat (BIT) @(negedge clk);
            got[i] = line;
        end
    endtask

    function automatic logic [11:0] tx_expect(input logic [7:0] d, input bit has_ext,
                                              input logic ext);
        logic [11:0] e = '0;
        e[8:1] = d;
        if (has_ext) begin
            e[9] = ext; e[10] = 1'b1;
        end else begin
            e[9] = 1'b1;
        end
        return e;
    endfunction

    initial begin
        repeat (150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [11:0] got;
        int base;

        // R12: reset state
        repeat (5) @(negedge clk);
        check("R12", "status in reset", status, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R12", "status", status, 8'h00);
        check("R12", "rx_data", rx_data, 8'h00);
        check("R12", "rx_bit8", rx_bit8, 1'b0);
        check("R12", "rx_irq", rx_irq, 1'b0);
        check("R12", "tx_busy", tx_busy, 1'b0);
        check("R12", "line idle", line, 1'b1);

        // R1 R5 R6 R7: receive sweep over modes and data values
        for (int c = 0; c < 4; c++) begin
            mode_sel = (c == 0) ? 2'b01 : (c == 1) ? 2'b10 : 2'b11;
            par_en   = (c == 1) || (c == 3);
            wake_en  = 1'b0;
            for (int k = 0; k < 8; k++) begin
                logic [7:0] v;
                logic       ex;
                v  = (k == 7) ? 8'hFF : 8'(k * 37);
                ex = (c >= 2) ? v[k % 2] : ^v;
                base = irq_cnt;
                send_rx(v, c != 0, ex, 1'b1);
                check("R5", "rx_data", rx_data, v);
                check("R5", "one irq", irq_cnt - base, 1);
                check("R6", "status", status,
                      {(c >= 2) ? ex : 1'b0, 7'b0000001});
                pulse_read();
                check("R11", "full cleared", status[0], 1'b0);
            end
        end

        // R7: bad parity then R11 clear
        mode_sel = 2'b01; par_en = 1'b1;
        send_rx(8'h01, 1, 1'b0, 1'b1);
        check("R7", "parity flag", status, 8'b0000_1001);
        pulse_stat();
        check("R11", "flags cleared", status, 8'b0000_0001);
        pulse_read();

        // R8: framing error, then a good frame after re-arming
        par_en = 1'b0;
        send_rx(8'h6C, 0, 1'b0, 1'b0);
        check("R8", "framing flag", status, 8'b0000_0101);
        check("R8", "data still loaded", rx_data, 8'h6C);
        pulse_stat(); pulse_read();
        send_rx(8'h93, 0, 1'b0, 1'b1);
        check("R8", "next frame after rearm", rx_data, 8'h93);
        pulse_read();

        // R9: overrun keeps old buffer and gives no second irq
        base = irq_cnt;
        send_rx(8'h11, 0, 1'b0, 1'b1);
        send_rx(8'h22, 0, 1'b0, 1'b1);
        check("R9", "overrun flag", status, 8'b0001_0001);
        check("R9", "old data kept", rx_data, 8'h11);
        check("R9", "single irq", irq_cnt - base, 1);
        pulse_stat(); pulse_read();

        // R6: nine-bit mode ignores parity enable
        mode_sel = 2'b11; par_en = 1'b1;
        send_rx(8'h01, 1, 1'b0, 1'b1);
        check("R6", "no parity flag in nine-bit", status, 8'b0000_0001);
        pulse_read();

        // R10: wakeup filtering
        wake_en = 1'b1;
        send_rx(8'h5A, 1, 1'b1, 1'b1);
        check("R10", "address frame accepted", rx_data, 8'h5A);
        check("R10", "address status", status, 8'b1000_0001);
        pulse_read();
        base = irq_cnt;
        send_rx(8'hC3, 1, 1'b0, 1'b0);
        check("R10", "data frame no irq", irq_cnt - base, 0);
        check("R10", "data frame buffer kept", rx_data, 8'h5A);
        check("R10", "data frame status kept", status, 8'b1000_0000);
        send_rx(8'h3C, 1, 1'b1, 1'b1);
        check("R10", "next address accepted", rx_data, 8'h3C);
        check("R10", "irq for address", irq_cnt - base, 1);
        pulse_read();
        wake_en = 1'b0;

        // R5: start glitch rejected
        base = irq_cnt;
        @(negedge clk) rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        check("R5", "glitch no irq", irq_cnt - base, 0);
        check("R5", "glitch no load", status[0], 1'b0);

        // R1 R3 R4: transmit sweep over modes, parity and pin type
        for (int c = 0; c < 4; c++) begin
            mode_sel = (c >= 2) ? 2'b11 : 2'b00;
            par_en   = (c == 1);
            od_en    = c[0];
            for (int k = 0; k < 8; k++) begin
                logic [7:0] v;
                logic       b8, ex;
                bit         he;
                v  = (k == 7) ? 8'hFF : 8'(k * 37 + 5);
                b8 = k[0];
                he = (c != 0);
                ex = (c >= 2) ? b8 : ^v;
                load_tx(v, b8);
                check("R2", "busy after load", tx_busy, 1'b1);
                tx_capture(he ? 11 : 10, got);
                check("R3", "frame bits", got, tx_expect(v, he, ex));
                repeat (BIT) @(negedge clk);
                check("R2", "idle after stop", tx_busy, 1'b0);
                check("R4", "pin enable when idle", txd_oe, !od_en);
            end
        end

        // R4: open-drain drives low only
        od_en = 1'b1; mode_sel = 2'b00; par_en = 1'b0;
        load_tx(8'h00, 1'b0);
        repeat (BIT) @(negedge clk);
        check("R4", "od low bit drives", {txd_oe, txd_o}, 2'b10);
        repeat (10 * BIT) @(negedge clk);
        od_en = 1'b0;

        // R2: load while busy is ignored
        fork
            tx_capture(10, got);
            begin
                repeat (5 * BIT) @(negedge clk);
                tx_data = 8'h0F; tx_load = 1'b1;
                @(negedge clk) tx_load = 1'b0;
            end
        join_none
        load_tx(8'hA5, 1'b0);
        wait fork;
        check("R2", "first frame intact", got, tx_expect(8'hA5, 0, 1'b0));
        repeat (BIT) @(negedge clk);
        check("R2", "not busy", tx_busy, 1'b0);
        begin
            int lows = 0;
            for (int i = 0; i < 3 * BIT; i++) begin
                @(negedge clk);
                if (line == 1'b0) lows++;
            end
            check("R2", "ignored load sent nothing", lows, 0);
        end

        finish_run();
    end
endmodule